// File: doc/BRIEF.md
# Bidirectional Bus Transceiver with Parity

This block joins two data buses of `WIDTH` bits through a transceiver whose direction is chosen by one input, and adds a parity generator and checker that share a single parity pin. When the transfer runs from side A to side B, the block drives side B with the side A word. It also drives the parity pin with a bit that makes the total count of ones odd or even, as the scheme select asks. When the transfer runs from side B to side A, the parity pin becomes an input. The word on side B and that incoming bit are then checked together against the selected scheme, and an active-low error flag reports a mismatch.

An active-low enable releases every driven pin: both data sides, the parity pin and the error flag. Each tri-state pin appears as three signals: the value seen on the wire, the value to drive, and a drive enable. A pad ring or a test harness resolves them. The logic is purely combinational. Each output follows its inputs within the same cycle.

Top module: `bxp_transceiver`

## Requirements
- R1: With the enable active (`en_n` = 0) and `dir_tx` = 1, `b_oe` is 1, `a_oe` is 0 and `b_out` equals `a_in`, whatever `b_in` holds.
- R2: With the enable active and `dir_tx` = 0, `a_oe` is 1, `b_oe` is 0 and `a_out` equals `b_in`, whatever `a_in` holds.
- R3: With `en_n` = 1, all four drive enables (`a_oe`, `b_oe`, `par_oe`, `err_n_oe`) are 0, whatever the direction.
- R4: `par_oe` is 1 only when the enable is active and `dir_tx` = 1. In receive mode the parity pin is never driven.
- R5: In transmit mode with `sel_odd` = 0 (even scheme), `par_out` is 1 when `a_in` holds an odd number of ones and 0 when it holds an even number.
- R6: In transmit mode with `sel_odd` = 1 (odd scheme), `par_out` is 1 when `a_in` holds an even number of ones and 0 when it holds an odd number.
- R7: In receive mode with `sel_odd` = 0, `err_n_out` is 0 (error) when the ones in `b_in` plus `par_in` add up to an odd count, and 1 otherwise.
- R8: In receive mode with `sel_odd` = 1, `err_n_out` is 0 when the ones in `b_in` plus `par_in` add up to an even count, and 1 otherwise.
- R9: With the enable active, `err_n_oe` is 1. In transmit mode `err_n_out` is 1 (no error).
- R10: Every `*_out` signal whose drive enable is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_n | input | 1 | Active-low enable for all driven pins |
| dir_tx | input | 1 | 1: transfer A to B (transmit), 0: transfer B to A (receive) |
| sel_odd | input | 1 | Parity scheme: 0 even, 1 odd |
| a_in | input | WIDTH | Value seen on side A pins |
| a_out | output | WIDTH | Value driven onto side A |
| a_oe | output | 1 | Drive enable for side A |
| b_in | input | WIDTH | Value seen on side B pins |
| b_out | output | WIDTH | Value driven onto side B |
| b_oe | output | 1 | Drive enable for side B |
| par_in | input | 1 | Value seen on the parity pin |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Drive enable for the parity pin |
| err_n_out | output | 1 | Active-low parity error flag |
| err_n_oe | output | 1 | Drive enable for the error flag |

## Verification
The parity pin changes role in the same cycle as the direction input. The bench therefore flips `dir_tx`, and `dir_tx` together with `en_n`, on consecutive cycles while `par_in` is held high. This shows that the pin stops driving in exactly the cycle the check begins to use it, and that the error flag is judged on the new direction at once. In each direction the sweep also loads the unused side with the complement of the live word. Any leak from the ignored side then shows up in the forwarded data or in the parity result of that same cycle. Every cycle is compared against a behavioural model that counts ones with a loop.

// File: rtl/bxp_pkg.sv
package bxp_pkg;
   typedef enum logic [1:0] {
      XF_OFF = 2'd0,
      XF_TX  = 2'd1,
      XF_RX  = 2'd2
   } xfer_mode_e;
endpackage

// File: rtl/bxp_mode_dec.sv
module bxp_mode_dec
   import bxp_pkg::*;
(
   input  logic       en_n,
   input  logic       dir_tx,
   output xfer_mode_e mode
);
   always_comb begin
      if (en_n)        mode = XF_OFF;
      else if (dir_tx) mode = XF_TX;
      else             mode = XF_RX;
   end
endmodule

// File: rtl/bxp_xor_tree.sv
module bxp_xor_tree #(
   parameter int W = 9
) (
   input  logic [W-1:0] din,
   output logic         odd
);
   localparam int LV = (W <= 1) ? 1 : $clog2(W);
   localparam int PW = 1 << LV;

   if (W < 1) begin : g_bad
      $error("bxp_xor_tree: W must be at least 1");
   end

   for (genvar k = 0; k <= LV; k++) begin : g_lvl
      localparam int N = PW >> k;
      logic [N-1:0] v;
      if (k == 0) begin : g_leaf
         assign v = PW'(din);
      end else begin : g_node
         for (genvar i = 0; i < N; i++) begin : g_x
            assign v[i] = g_lvl[k-1].v[2*i] ^ g_lvl[k-1].v[2*i+1];
         end
      end
   end

   assign odd = g_lvl[LV].v[0];
endmodule

// File: rtl/bxp_parity_unit.sv
module bxp_parity_unit
   import bxp_pkg::*;
#(
   parameter int WIDTH        = 8,
   parameter bit SHARE_TREE   = 1'b1
) (
   input  xfer_mode_e       mode,
   input  logic             sel_odd,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             par_in,
   output logic             par_gen,
   output logic             err_hit
);
   localparam int TW = WIDTH + 1;

   if (SHARE_TREE) begin : g_shared
      logic [TW-1:0] sel_word;
      logic          tree_odd;
      logic          flag;
      always_comb begin
         if (mode == XF_TX) sel_word = {1'b0, a_in};
         else               sel_word = {par_in, b_in};
      end
      bxp_xor_tree #(.W(TW)) u_tree (.din(sel_word), .odd(tree_odd));
      assign flag    = tree_odd ^ sel_odd;
      assign par_gen = flag;
      assign err_hit = flag;
   end else begin : g_split
      logic odd_a;
      logic odd_b;
      bxp_xor_tree #(.W(WIDTH)) u_tree_a (.din(a_in), .odd(odd_a));
      bxp_xor_tree #(.W(TW))    u_tree_b (.din({par_in, b_in}), .odd(odd_b));
      assign par_gen = odd_a ^ sel_odd;
      assign err_hit = odd_b ^ sel_odd;
   end
endmodule

// File: rtl/bxp_transceiver.sv
module bxp_transceiver
   import bxp_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit SHARE_TREE = 1'b1
) (
   input  logic             en_n,
   input  logic             dir_tx,
   input  logic             sel_odd,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe,
   input  logic             par_in,
   output logic             par_out,
   output logic             par_oe,
   output logic             err_n_out,
   output logic             err_n_oe
);
   localparam logic [WIDTH-1:0] ZW = '0;

   if (WIDTH < 1) begin : g_bad_width
      $error("bxp_transceiver: WIDTH must be at least 1");
   end

   xfer_mode_e mode;
   logic       par_gen;
   logic       err_hit;

   bxp_mode_dec u_dec (
      .en_n   (en_n),
      .dir_tx (dir_tx),
      .mode   (mode)
   );

   bxp_parity_unit #(
      .WIDTH      (WIDTH),
      .SHARE_TREE (SHARE_TREE)
   ) u_par (
      .mode    (mode),
      .sel_odd (sel_odd),
      .a_in    (a_in),
      .b_in    (b_in),
      .par_in  (par_in),
      .par_gen (par_gen),
      .err_hit (err_hit)
   );

   always_comb begin
      a_out     = ZW;
      a_oe      = 1'b0;
      b_out     = ZW;
      b_oe      = 1'b0;
      par_out   = 1'b0;
      par_oe    = 1'b0;
      err_n_out = 1'b0;
      err_n_oe  = 1'b0;
      unique case (mode)
         XF_TX: begin
            b_out     = a_in;
            b_oe      = 1'b1;
            par_out   = par_gen;
            par_oe    = 1'b1;
            err_n_out = 1'b1;
            err_n_oe  = 1'b1;
         end
         XF_RX: begin
            a_out     = b_in;
            a_oe      = 1'b1;
            err_n_out = ~err_hit;
            err_n_oe  = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/bxp_transceiver_chk.sv
module bxp_transceiver_chk #(
   parameter int WIDTH = 8
) (
   input logic             en_n,
   input logic             dir_tx,
   input logic             sel_odd,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] a_out,
   input logic             a_oe,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic             b_oe,
   input logic             par_in,
   input logic             par_out,
   input logic             par_oe,
   input logic             err_n_out,
   input logic             err_n_oe
);
   logic known;
   assign known = !$isunknown({en_n, dir_tx, sel_odd, a_in, b_in, par_in});

   always_comb begin
      if (known) begin
         if (!en_n && dir_tx)
            assert_tx_path_R1: assert (b_oe && !a_oe && b_out == a_in);
         if (!en_n && !dir_tx)
            assert_rx_path_R2: assert (a_oe && !b_oe && a_out == b_in);
         if (en_n)
            assert_release_R3: assert (!a_oe && !b_oe && !par_oe && !err_n_oe);
         assert_par_dir_R4: assert (!par_oe || (!en_n && dir_tx));
         if (par_oe) begin
            // R5 and R6: total ones of word plus parity follows the scheme
            assert_gen_R5_R6: assert (($countones({par_out, a_in}) % 2 == 1) == sel_odd);
         end
         if (!en_n && !dir_tx) begin
            // R7 and R8: flag low exactly when the received total breaks the scheme
            assert_chk_R7_R8: assert (err_n_out == (($countones({par_in, b_in}) % 2 == 1) == sel_odd));
         end
         if (!en_n)
            assert_err_drv_R9: assert (err_n_oe && (!dir_tx ? 1'b1 : err_n_out));
         assert_quiet_R10: assert ((a_oe || a_out == '0) && (b_oe || b_out == '0)
                                   && (par_oe || !par_out) && (err_n_oe || !err_n_out));
      end
   end
endmodule

bind bxp_transceiver bxp_transceiver_chk #(.WIDTH(WIDTH)) u_chk (
   .en_n      (en_n),
   .dir_tx    (dir_tx),
   .sel_odd   (sel_odd),
   .a_in      (a_in),
   .a_out     (a_out),
   .a_oe      (a_oe),
   .b_in      (b_in),
   .b_out     (b_out),
   .b_oe      (b_oe),
   .par_in    (par_in),
   .par_out   (par_out),
   .par_oe    (par_oe),
   .err_n_out (err_n_out),
   .err_n_oe  (err_n_oe)
);

// File: tb/bxp_transceiver_tb.sv
module bxp_transceiver_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         en_n, dir_tx, sel_odd, par_in;
   logic [W-1:0] a_in, b_in;
   logic [W-1:0] a_out, b_out;
   logic         a_oe, b_oe, par_out, par_oe, err_n_out, err_n_oe;
   int           checks = 0;
   int           errors = 0;
   bit           done = 0;

   always #10 clk = ~clk;

   bxp_transceiver #(.WIDTH(W)) u_dut (
      .en_n(en_n), .dir_tx(dir_tx), .sel_odd(sel_odd),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
      .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
      .err_n_out(err_n_out), .err_n_oe(err_n_oe)
   );

   function automatic int ones(input logic [W-1:0] v);
      int n = 0;
      for (int i = 0; i < W; i++) if (v[i]) n++;
      return n;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // behavioural model compared on each cycle
   task automatic compare();
      int  cnt;
      bit  en, tx;
      en = !en_n;
      tx = dir_tx;
      if (!en) begin
         chk("R3", "drive enables", {a_oe, b_oe, par_oe, err_n_oe}, 0);
         chk("R10", "idle values", {a_out, b_out, par_out, err_n_out}, 0);
      end else if (tx) begin
         chk("R1", "b_out", b_out, a_in);
         chk("R1", "oe a/b", {a_oe, b_oe}, 2'b01);
         chk("R10", "a_out idle", a_out, 0);
         chk("R4", "par_oe tx", par_oe, 1);
         cnt = ones(a_in);
         if (!sel_odd) chk("R5", "par_out even", par_out, (cnt % 2 == 1));
         else          chk("R6", "par_out odd", par_out, (cnt % 2 == 0));
         chk("R9", "err tx", {err_n_oe, err_n_out}, 2'b11);
      end else begin
         chk("R2", "a_out", a_out, b_in);
         chk("R2", "oe a/b", {a_oe, b_oe}, 2'b10);
         chk("R10", "b_out/par idle", {b_out, par_out}, 0);
         chk("R4", "par_oe rx", par_oe, 0);
         cnt = ones(b_in) + (par_in ? 1 : 0);
         if (!sel_odd) chk("R7", "err even", err_n_out, (cnt % 2 == 0));
         else          chk("R8", "err odd", err_n_out, (cnt % 2 == 1));
         chk("R9", "err_n_oe rx", err_n_oe, 1);
      end
   endtask

   task automatic apply(input bit e_n, input bit d, input bit s,
                        input logic [W-1:0] a, input logic [W-1:0] b, input bit p);
      @(posedge clk);
      #2;
      en_n = e_n; dir_tx = d; sel_odd = s; a_in = a; b_in = b; par_in = p;
      @(negedge clk);
      compare();
   endtask

   initial begin
      rst_n = 1'b0;
      en_n = 1'b1; dir_tx = 1'b0; sel_odd = 1'b0; a_in = '0; b_in = '0; par_in = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: released bus, R3 and R10
      compare();
      rst_n = 1'b1;

      // full sweep: ignored side carries the complement of the live word
      for (int e = 0; e < 2; e++)
         for (int d = 0; d < 2; d++)
            for (int s = 0; s < 2; s++)
               for (int v = 0; v < 256; v++)
                  for (int p = 0; p < 2; p++) begin
                     if (d == 1) apply(e[0], 1'b1, s[0], v[7:0], ~v[7:0], p[0]);
                     else        apply(e[0], 1'b0, s[0], ~v[7:0], v[7:0], p[0]);
                  end

      // same-cycle role change of the parity pin (R4, R7, R9)
      for (int k = 0; k < 16; k++) begin
         apply(1'b0, k[0], k[1], 8'hA5 ^ k[7:0], 8'h3C + k[7:0], 1'b1);
      end
      // direction and enable flipping together
      for (int k = 0; k < 8; k++) begin
         apply(k[0], ~k[0], k[2], 8'hFF, 8'h00, 1'b1);
      end
      // boundary words
      apply(1'b0, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0);
      apply(1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b0);
      apply(1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b1);
      apply(1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule